// File: doc/BRIEF.md
# TDM Time-Slot Channel Router

This block sits behind the receive side of a time-division multiplexed serial link. Each byte that arrives in a time slot goes to one of two serial controllers. Bytes in even slots go to one controller and bytes in odd slots go to the other. Each controller keeps its own pointer into a shared assignment table. The entry under that pointer decides four things: whether the byte is kept, which bits survive, which logical channel receives the byte, and whether the pointer returns to its own start afterwards. The kept byte leaves the block as a masked byte with its channel number, its controller and a one-cycle strobe.

The table can be rewritten through a simple write port while traffic runs. A write takes effect the next time that entry is used. The block also watches for two controllers delivering to the same logical channel and raises a sticky flag when that happens. Receive and transmit routing each use their own instance of the block, so each direction has an independent table.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset `out_valid` and `collision` are 0, and the whole table reads as invalid entries.
- R2: The byte presented with `frame_sync` high is slot 0. Each later byte takes the next slot number, counting modulo `SLOTS_PER_FRAME`. Even slots are served by controller 0 and odd slots by controller 1, and `out_ctrl` carries that controller number.
- R3: Controller 0 begins at entry `START_EVEN` (0) and controller 1 at entry `START_ODD` (16). Each byte served by a controller moves that controller's pointer forward by one entry. The other controller's pointer does not move.
- R4: When a controller uses an entry whose wrap bit is set, its next byte uses that controller's own start entry.
- R5: A byte that arrives with `frame_sync` high returns both pointers and the slot count to their start values before that byte is routed, including in the middle of a frame.
- R6: A byte whose entry has the valid bit clear produces no `out_valid` strobe. The controller's pointer still advances past that entry.
- R7: One cycle after an accepted byte, `out_valid` pulses for exactly one cycle. In that cycle `out_byte` equals the input byte ANDed with the entry mask, `out_chan` equals the entry channel and `out_ctrl` equals the serving controller.
- R8: An entry is 15 bits wide: bit 14 valid, bit 13 wrap, bits 12:5 mask, bits 4:0 channel. A table write takes effect at the next use of that entry. If a write hits the entry being read in the same cycle, the byte of that cycle still uses the old contents.
- R9: When a valid entry routes a byte of controller c to a channel that the other controller has already received since the last clear, `collision` goes to 1 in the next cycle. It stays at 1 until it is cleared.
- R10: A pulse on `coll_clr` clears `collision` and forgets every channel owner. If a byte that would collide arrives in the same cycle as the clear, the clear wins and `collision` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A slot byte is present on `rx_byte` |
| frame_sync | input | 1 | Marks the present byte as slot 0 (qualified by `rx_valid`) |
| rx_byte | input | 8 | Slot byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Entry index to write |
| cfg_wdata | input | 15 | New entry contents (layout in R8) |
| coll_clr | input | 1 | Clears the collision flag and the channel ownership record |
| out_valid | output | 1 | One-cycle strobe for a routed byte |
| out_ctrl | output | 1 | Controller that served the byte |
| out_chan | output | 5 | Logical channel of the byte |
| out_byte | output | 8 | Masked byte |
| collision | output | 1 | Sticky flag: two controllers delivered to the same channel |

## Verification
Two pairs of events can share a cycle. The first is a table write and the routing read of the same entry. The bench provokes it by writing the entry under a pointer in the very cycle that entry routes a byte. The old mask must then appear on the output, and the new mask must appear on the following lap. The second is a collision clear and a byte that would collide. The bench raises `coll_clr` together with such a byte and expects `collision` to stay low. A later collision must then be detected again from fresh ownership.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   localparam int NUM_CTRL = 2;

   typedef enum logic {
      CTRL_EVEN = 1'b0,
      CTRL_ODD  = 1'b1
   } ctrl_e;
endpackage

// File: rtl/tsr_table.sv
module tsr_table #(
   parameter int DEPTH   = 64,
   parameter int ENTRY_W = 15,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  waddr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [ADDR_W-1:0]  raddr,
   output logic [ENTRY_W-1:0] rdata
);
   logic [ENTRY_W-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("tsr_table: DEPTH must be at least 2");
   end

   // the read returns contents before any same-cycle write lands
   assign rdata = mem[raddr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata)); // R8
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker #(
   parameter int DEPTH = 64,
   parameter int START = 0,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              step,
   input  logic              wrap,
   output logic [ADDR_W-1:0] cur_ptr
);
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] inc_ptr;

   if (START >= DEPTH) begin : g_bad_start
      $error("tsr_walker: START outside table");
   end

   assign cur_ptr = sync ? START_A : ptr_q;
   assign inc_ptr = (cur_ptr == LAST_A) ? '0 : cur_ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= START_A;
      end else if (step) begin
         ptr_q <= wrap ? START_A : inc_ptr;
      end else if (sync) begin
         ptr_q <= START_A;
      end
   end

   AST_WRAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      step && wrap |=> ptr_q == START_A); // R4
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step && !wrap && cur_ptr != LAST_A |=> ptr_q == $past(cur_ptr) + 1'b1); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !sync |=> $stable(ptr_q)); // R3
   AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
      sync && !step |=> ptr_q == START_A); // R5
endmodule

// File: rtl/tsr_collide.sv
module tsr_collide #(
   parameter int CHAN_W = 5,
   localparam int CHANS = 1 << CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              ctrl,
   input  logic [CHAN_W-1:0] chan,
   input  logic              clr,
   output logic              flag
);
   import tsr_pkg::*;

   logic [NUM_CTRL-1:0][CHANS-1:0] owned;

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_owner
      logic [CHANS-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q <= '0;
         end else if (clr) begin
            bits_q <= '0;
         end else if (hit && ctrl == g[0]) begin
            bits_q[chan] <= 1'b1;
         end
      end
      assign owned[g] = bits_q;
   end

   logic other_owns;
   assign other_owns = owned[~ctrl][chan];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (clr) begin
         flag <= 1'b0;
      end else if (hit && other_owns) begin
         flag <= 1'b1;
      end
   end

   AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag); // R9
   AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag); // R10
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
   parameter int NUM_ENTRIES     = 64,
   parameter int DATA_W          = 8,
   parameter int CHAN_W          = 5,
   parameter int SLOTS_PER_FRAME = 64,
   parameter int START_EVEN      = 0,
   parameter int START_ODD       = 16,
   parameter bit SPLIT_BY_PARITY = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_ENTRIES),
   localparam int ENTRY_W = 2 + DATA_W + CHAN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic               frame_sync,
   input  logic [DATA_W-1:0]  rx_byte,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [ENTRY_W-1:0] cfg_wdata,
   input  logic               coll_clr,
   output logic               out_valid,
   output logic               out_ctrl,
   output logic [CHAN_W-1:0]  out_chan,
   output logic [DATA_W-1:0]  out_byte,
   output logic               collision
);
   import tsr_pkg::*;

   localparam int SLOT_W    = $clog2(SLOTS_PER_FRAME);
   localparam int MASK_LSB  = CHAN_W;
   localparam int WRAP_BIT  = CHAN_W + DATA_W;
   localparam int VALID_BIT = WRAP_BIT + 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_FRAME - 1);

   if (SLOTS_PER_FRAME < 2 || (1 << SLOT_W) != SLOTS_PER_FRAME) begin : g_bad_slots
      $error("tdm_slot_router: SLOTS_PER_FRAME must be a power of two");
   end
   if (START_EVEN == START_ODD) begin : g_bad_starts
      $error("tdm_slot_router: controllers need distinct start entries");
   end

   // slot numbering
   logic              sync;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] cur_slot;
   ctrl_e             ctrl;

   assign sync     = rx_valid & frame_sync;
   assign cur_slot = sync ? '0 : slot_q;

   if (SPLIT_BY_PARITY) begin : g_split
      assign ctrl = ctrl_e'(cur_slot[0]);
   end else begin : g_single
      assign ctrl = CTRL_EVEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (rx_valid) begin
         slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      end else if (frame_sync) begin
         slot_q <= slot_q;
      end
   end

   // table and per-controller pointers
   logic [ENTRY_W-1:0] entry;
   logic [ADDR_W-1:0]  cur_ptr [NUM_CTRL];
   logic               ent_valid;
   logic               ent_wrap;
   logic [DATA_W-1:0]  ent_mask;
   logic [CHAN_W-1:0]  ent_chan;

   assign ent_valid = entry[VALID_BIT];
   assign ent_wrap  = entry[WRAP_BIT];
   assign ent_mask  = entry[MASK_LSB +: DATA_W];
   assign ent_chan  = entry[CHAN_W-1:0];

   tsr_table #(
      .DEPTH   (NUM_ENTRIES),
      .ENTRY_W (ENTRY_W)
   ) i_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .waddr (cfg_addr),
      .wdata (cfg_wdata),
      .raddr (cur_ptr[ctrl]),
      .rdata (entry)
   );

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_walk
      logic step;
      assign step = rx_valid && (ctrl == ctrl_e'(g));
      tsr_walker #(
         .DEPTH (NUM_ENTRIES),
         .START ((g == 0) ? START_EVEN : START_ODD)
      ) i_walker (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync    (sync),
         .step    (step),
         .wrap    (ent_wrap),
         .cur_ptr (cur_ptr[g])
      );
   end

   // ownership tracking
   logic accept;
   assign accept = rx_valid && ent_valid;

   tsr_collide #(
      .CHAN_W (CHAN_W)
   ) i_collide (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (accept),
      .ctrl  (ctrl),
      .chan  (ent_chan),
      .clr   (coll_clr),
      .flag  (collision)
   );

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ctrl  <= 1'b0;
         out_chan  <= '0;
         out_byte  <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_ctrl <= ctrl;
            out_chan <= ent_chan;
            out_byte <= rx_byte & ent_mask;
         end
      end
   end

   AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(rx_valid)); // R7
   AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (out_byte & ~$past(ent_mask)) == '0); // R7
   AST_DROP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !ent_valid |=> !out_valid); // R6
   AST_SYNC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      sync && ent_valid |=> out_ctrl == 1'b0); // R2
endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
   localparam int CLK_PERIOD = 10;
   localparam int START0 = 0;
   localparam int START1 = 16;

   typedef struct {
      int          ctrl;
      int          chan;
      logic [7:0]  data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic        frame_sync = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [14:0] cfg_wdata = '0;
   logic        coll_clr = 1'b0;
   logic        out_valid;
   logic        out_ctrl;
   logic [4:0]  out_chan;
   logic [7:0]  out_byte;
   logic        collision;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t        sb [$];
   logic [14:0] tbl [64];
   int          bptr [2];
   int          bslot;
   bit          own [2][32];
   bit          coll_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_slot_router i_tdm_slot_router (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .frame_sync(frame_sync),
      .rx_byte(rx_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .coll_clr(coll_clr), .out_valid(out_valid), .out_ctrl(out_ctrl),
      .out_chan(out_chan), .out_byte(out_byte), .collision(collision)
   );

   function automatic logic [14:0] mk(bit v, bit w, logic [7:0] m, int ch);
      return {v, w, m, 5'(ch)};
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: one stimulus cycle, model updated from the requirements
   task automatic drive(bit rxv, bit sync, logic [7:0] data, bit wr, int waddr,
                        logic [14:0] wdata, bit clr, string tag);
      @(posedge clk); #1;
      rx_valid = rxv; frame_sync = sync; rx_byte = data;
      cfg_we = wr; cfg_addr = 6'(waddr); cfg_wdata = wdata; coll_clr = clr;
      if (rxv) begin
         int slot, c, p;
         logic [14:0] e;
         exp_t it;
         slot = sync ? 0 : bslot;
         c = slot % 2;
         if (sync) begin bptr[0] = START0; bptr[1] = START1; end
         p = bptr[c];
         e = tbl[p];
         bptr[c] = e[13] ? (c == 0 ? START0 : START1) : (p + 1) % 64;
         bslot = (slot + 1) % 64;
         if (e[14]) begin
            it.ctrl = c; it.chan = int'(e[4:0]); it.data = data & e[12:5]; it.tag = tag;
            sb.push_back(it);
            if (!clr) begin
               if (own[1-c][e[4:0]]) coll_exp = 1'b1;
               own[c][e[4:0]] = 1'b1;
            end
         end
      end
      if (clr) begin
         coll_exp = 1'b0;
         foreach (own[i, j]) own[i][j] = 1'b0;
      end
      if (wr) tbl[waddr] = wdata;
      @(posedge clk); #1;
      rx_valid = 0; frame_sync = 0; cfg_we = 0; coll_clr = 0;
   endtask

   task automatic send(bit sync, logic [7:0] data, string tag);
      drive(1'b1, sync, data, 1'b0, 0, '0, 1'b0, tag);
   endtask

   task automatic wr_entry(int a, logic [14:0] d);
      drive(1'b0, 1'b0, 8'h00, 1'b1, a, d, 1'b0, "cfg");
   endtask

   task automatic check_coll(string tag);
      @(negedge clk);
      check(collision == coll_exp, tag, int'(collision), int'(coll_exp));
   endtask

   // monitor: compare each strobe with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R6 R7 unexpected strobe", int'(out_chan), -1);
            end else begin
               exp_t it;
               it = sb.pop_front();
               check(out_ctrl == it.ctrl[0], {it.tag, " ctrl"}, int'(out_ctrl), it.ctrl);
               check(out_chan == 5'(it.chan), {it.tag, " chan"}, int'(out_chan), it.chan);
               check(out_byte == it.data, {it.tag, " byte"}, int'(out_byte), int'(it.data));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (tbl[i]) tbl[i] = '0;
      foreach (own[i, j]) own[i][j] = 1'b0;
      bptr[0] = START0; bptr[1] = START1; bslot = 0; coll_exp = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(collision == 1'b0, "R1 collision", int'(collision), 0);

      // R1: unprogrammed table routes nothing
      send(1'b1, 8'h5A, "R1");
      send(1'b0, 8'h5B, "R1");

      for (int i = 0; i < 16; i++) begin
         wr_entry(START0 + i, mk(1'b1, i == 3, 8'hFF, i));
         wr_entry(START1 + i, mk(1'b1, i == 2, 8'hFF, 16 + i));
      end

      // R2 R3 R4: parity split, independent walks, wrap to own start
      send(1'b1, 8'h30, "R2 R3");
      for (int k = 1; k <= 8; k++) send(1'b0, 8'(8'h30 + k), "R2 R3 R4");
      check_coll("R9 no overlap");

      // R8: mask change applies at next use; R7 masking
      wr_entry(1, mk(1'b1, 1'b0, 8'h0F, 1));
      send(1'b1, 8'hA5, "R7");
      send(1'b0, 8'hA6, "R7");
      send(1'b0, 8'hA7, "R7 R8");
      // R6: invalid entry drops byte but pointer advances
      wr_entry(2, mk(1'b0, 1'b0, 8'hFF, 2));
      send(1'b0, 8'h41, "R6");
      send(1'b0, 8'h42, "R6");
      send(1'b0, 8'h43, "R6");
      send(1'b0, 8'h44, "R6");
      // R5: mid-frame sync
      send(1'b1, 8'h50, "R5");
      send(1'b0, 8'h51, "R5");
      // R8: write to entry read in the same cycle
      drive(1'b1, 1'b0, 8'hC3, 1'b1, 1, mk(1'b1, 1'b0, 8'hF0, 1), 1'b0, "R8 old");
      send(1'b1, 8'hC4, "R8");
      send(1'b0, 8'hC5, "R8");
      send(1'b0, 8'hC6, "R8 new");

      // R9: controller 1 entry aimed at channel already owned by controller 0
      wr_entry(17, mk(1'b1, 1'b0, 8'hFF, 0));
      send(1'b0, 8'h61, "R9");
      check_coll("R9 set");
      repeat (3) @(posedge clk);
      check_coll("R9 sticky");

      // R10: clear, then clear racing a colliding byte
      drive(1'b0, 1'b0, 8'h00, 1'b0, 0, '0, 1'b1, "R10");
      check_coll("R10 cleared");
      send(1'b1, 8'h70, "R10");
      send(1'b0, 8'h71, "R10");
      send(1'b0, 8'h72, "R10");
      drive(1'b1, 1'b0, 8'h73, 1'b0, 0, '0, 1'b1, "R10 race");
      check_coll("R10 clear wins");
      for (int k = 4; k <= 8; k++) send(1'b0, 8'(8'h70 + k), "R10");
      check_coll("R10 fresh owners");
      send(1'b1, 8'h80, "R9");
      send(1'b0, 8'h81, "R9");
      send(1'b0, 8'h82, "R9");
      send(1'b0, 8'h83, "R9");
      check_coll("R9 detected again");

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R6 R7 missing strobes", sb.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule